// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the operand-addressing fields of a decoded instruction into a 32-bit memory offset. A decoder hands it a mode code, two 3-bit register selects, a 2-bit scale code and a 32-bit displacement field. It also receives the current contents of all eight general-purpose registers on one flat input bus. From these it computes the offset and a flag that says whether the operand lives in memory.

The arithmetic is purely combinational. A generate-selected output stage either registers the result or passes it straight through. When it registers, an input strobe loads the stage and a valid output follows one cycle later. Segment translation, limit checking and the memory access itself belong to the logic downstream.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode code 2 (absolute) gives an offset equal to the full 32-bit displacement, with the memory flag set. Neither selected register has any effect.
- R2: Mode code 3 (register indirect) gives an offset equal to the base-selected register, with the memory flag set. The displacement has no effect.
- R3: Mode code 4 adds to the base register the sign extension of displacement bits [7:0], and sets the memory flag. Displacement bits [31:8] have no effect.
- R4: Mode code 5 adds the full 32-bit displacement to the base register, and sets the memory flag.
- R5: Mode codes 6 and 7 give base + index × 2^scale + displacement, with the memory flag set. Scale codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8. Code 6 takes the sign extension of displacement bits [7:0], and code 7 takes all 32 bits.
- R6: The base and the index are each picked by a 3-bit select from the eight registers. Register k sits at bits [32k+31:32k] of the register bus.
- R7: Mode code 0 (register operand) and mode code 1 (immediate operand) give offset 0 with the memory flag clear.
- R8: Mode codes 8 through 15 are unused and give offset 0 with the memory flag clear.
- R9: All sums wrap modulo 2^32, and no overflow indication exists.
- R10: When registered (the default), the output stage loads when the input strobe is high. The valid output is high exactly one cycle after each strobe. The offset and the flag hold their values while the strobe is low.
- R11: While reset is high, and after it, until the first strobe, the valid output, the offset and the memory flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: inputs hold an address request |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 3 | Register number used as base |
| index_sel | input | 3 | Register number used as index |
| scale_code | input | 2 | Index shift amount (factor 1/2/4/8) |
| disp | input | 32 | Displacement or absolute address field |
| gpr_bus | input | 256 | All eight register values, register k at [32k+31:32k] |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Computed operand offset |
| out_mem | output | 1 | Operand needs a memory access |

## Verification
The bench drives an 8-bit displacement whose upper field holds junk, with bit 7 both set and clear. A design that took the wrong bits, or extended with zeros, would return an offset off by a multiple of 256. Every scale code is used with a nonzero index. This exposes a swapped or off-by-one shift, which would double or halve the index term. Sums that cross 2^32 catch an adder that saturates or widens, and a sweep of the base select over all eight registers catches a mis-sliced register bus. The register, immediate and unused modes are fed nonzero inputs to show a nonzero offset or a set flag leaking through. An idle stretch with changed inputs shows an output stage that reloads without a strobe.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG      = 4'd0,
    MODE_IMM      = 4'd1,
    MODE_ABS      = 4'd2,
    MODE_INDIR    = 4'd3,
    MODE_BASE_D8  = 4'd4,
    MODE_BASE_D32 = 4'd5,
    MODE_SIDX_D8  = 4'd6,
    MODE_SIDX_D32 = 4'd7
  } ea_mode_e;

  typedef struct packed {
    logic mem;
    logic use_base;
    logic use_index;
    logic disp_en;
    logic disp_long;
  } ea_ctl_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output ea_ctl_t           ctl
);

  always_comb begin
    ctl = '0;
    case (mode)
      MODE_ABS: begin
        ctl.mem       = 1'b1;
        ctl.disp_en   = 1'b1;
        ctl.disp_long = 1'b1;
      end
      MODE_INDIR: begin
        ctl.mem      = 1'b1;
        ctl.use_base = 1'b1;
      end
      MODE_BASE_D8: begin
        ctl.mem      = 1'b1;
        ctl.use_base = 1'b1;
        ctl.disp_en  = 1'b1;
      end
      MODE_BASE_D32: begin
        ctl.mem       = 1'b1;
        ctl.use_base  = 1'b1;
        ctl.disp_en   = 1'b1;
        ctl.disp_long = 1'b1;
      end
      MODE_SIDX_D8: begin
        ctl.mem       = 1'b1;
        ctl.use_base  = 1'b1;
        ctl.use_index = 1'b1;
        ctl.disp_en   = 1'b1;
      end
      MODE_SIDX_D32: begin
        ctl.mem       = 1'b1;
        ctl.use_base  = 1'b1;
        ctl.use_index = 1'b1;
        ctl.disp_en   = 1'b1;
        ctl.disp_long = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/ea_reg_select.sv
module ea_reg_select #(
  parameter int unsigned NREG = 8,
  parameter int unsigned W    = 32,
  localparam int unsigned SELW = $clog2(NREG)
) (
  input  logic [NREG*W-1:0] reg_bus,
  input  logic [SELW-1:0]   sel,
  output logic [W-1:0]      value
);

  logic [W-1:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_unpack
    assign regs[k] = reg_bus[k*W +: W];
  end

  assign value = regs[sel];

endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import ea_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned SCALE_W = 2
) (
  input  ea_ctl_t            ctl,
  input  logic [W-1:0]       base_val,
  input  logic [W-1:0]       index_val,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic [W-1:0]       disp,
  output logic [W-1:0]       offset
);

  logic [W-1:0] base_term;
  logic [W-1:0] index_term;
  logic [W-1:0] disp_short;
  logic [W-1:0] disp_term;

  assign disp_short = {{(W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

  always_comb begin
    base_term  = ctl.use_base  ? base_val : '0;
    index_term = ctl.use_index ? (index_val << scale_code) : '0;
    if (!ctl.disp_en)
      disp_term = '0;
    else if (ctl.disp_long)
      disp_term = disp;
    else
      disp_term = disp_short;
  end

  // sum truncated to W bits: wraps modulo 2^W
  assign offset = base_term + index_term + disp_term;

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int unsigned W          = 32,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_offset,
  input  logic         in_mem,
  output logic         out_valid,
  output logic [W-1:0] out_offset,
  output logic         out_mem
);

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid  <= 1'b0;
        out_offset <= '0;
        out_mem    <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          out_offset <= in_offset;
          out_mem    <= in_mem;
        end
      end
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_offset) && $stable(out_mem)));
  end else begin : g_pass
    assign out_valid  = in_valid;
    assign out_offset = in_offset;
    assign out_mem    = in_mem;
  end

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int unsigned NREG       = 8,
  parameter int unsigned W          = 32,
  parameter int unsigned SCALE_W    = 2,
  parameter int unsigned SHORT_W    = 8,
  parameter bit          REGISTERED = 1'b1,
  localparam int unsigned SELW      = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [MODE_W-1:0]   mode,
  input  logic [SELW-1:0]     base_sel,
  input  logic [SELW-1:0]     index_sel,
  input  logic [SCALE_W-1:0]  scale_code,
  input  logic [W-1:0]        disp,
  input  logic [NREG*W-1:0]   gpr_bus,
  output logic                out_valid,
  output logic [W-1:0]        out_offset,
  output logic                out_mem
);

  ea_ctl_t      ctl;
  logic [W-1:0] base_val;
  logic [W-1:0] index_val;
  logic [W-1:0] comb_offset;

  ea_mode_decode u_dec (
    .mode (mode),
    .ctl  (ctl)
  );

  ea_reg_select #(.NREG(NREG), .W(W)) u_base_sel (
    .reg_bus (gpr_bus),
    .sel     (base_sel),
    .value   (base_val)
  );

  ea_reg_select #(.NREG(NREG), .W(W)) u_index_sel (
    .reg_bus (gpr_bus),
    .sel     (index_sel),
    .value   (index_val)
  );

  ea_offset_calc #(.W(W), .SHORT_W(SHORT_W), .SCALE_W(SCALE_W)) u_calc (
    .ctl        (ctl),
    .base_val   (base_val),
    .index_val  (index_val),
    .scale_code (scale_code),
    .disp       (disp),
    .offset     (comb_offset)
  );

  ea_out_stage #(.W(W), .REGISTERED(REGISTERED)) u_out (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_offset  (comb_offset),
    .in_mem     (ctl.mem),
    .out_valid  (out_valid),
    .out_offset (out_offset),
    .out_mem    (out_mem)
  );

  // R1: absolute mode passes the displacement through untouched
  a_r1_abs_offset: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ABS) |-> (comb_offset == disp && ctl.mem));

  // R2: indirect mode yields the selected register
  a_r2_indirect: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_INDIR) |-> (comb_offset == base_val && ctl.mem));

  // R7: register and immediate operands need no memory
  a_r7_no_mem_operand: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REG || mode == MODE_IMM) |-> (comb_offset == '0 && !ctl.mem));

  // R8: unused codes
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (mode > MODE_SIDX_D32) |-> (comb_offset == '0 && !ctl.mem));

  // R11: outputs idle after reset until a strobe arrives
  a_r11_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_offset == '0 && !out_mem));

endmodule

// File: tb/ea_gen_unit_test.sv
module ea_gen_unit_test;

  typedef struct {
    logic [31:0] off;
    logic        mem;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   mode = '0;
  logic [2:0]   base_sel = '0;
  logic [2:0]   index_sel = '0;
  logic [1:0]   scale_code = '0;
  logic [31:0]  disp = '0;
  logic [255:0] gpr_bus;
  logic         out_valid;
  logic [31:0]  out_offset;
  logic         out_mem;

  logic [31:0] regs [8];
  exp_t        sb [$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  for (genvar k = 0; k < 8; k++) begin : g_pack
    assign gpr_bus[k*32 +: 32] = regs[k];
  end

  ea_gen_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .base_sel(base_sel), .index_sel(index_sel), .scale_code(scale_code),
    .disp(disp), .gpr_bus(gpr_bus),
    .out_valid(out_valid), .out_offset(out_offset), .out_mem(out_mem)
  );

  function automatic exp_t model(input logic [3:0] m, input logic [2:0] b,
                                 input logic [2:0] x, input logic [1:0] s,
                                 input logic [31:0] d, input string tag);
    exp_t e;
    logic [31:0] d8;
    logic [31:0] fac;
    d8  = 32'($signed(d[7:0]));
    fac = 32'd1 * (32'd1 << s);
    e.tag = tag;
    e.mem = 1'b1;
    case (m)
      4'd2: e.off = d;
      4'd3: e.off = regs[b];
      4'd4: e.off = regs[b] + d8;
      4'd5: e.off = regs[b] + d;
      4'd6: e.off = regs[b] + regs[x] * fac + d8;
      4'd7: e.off = regs[b] + regs[x] * fac + d;
      default: begin e.off = 32'd0; e.mem = 1'b0; end
    endcase
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] m, input logic [2:0] b,
                       input logic [2:0] x, input logic [1:0] s,
                       input logic [31:0] d, input string tag);
    @(negedge clk);
    mode = m; base_sel = b; index_sel = x; scale_code = s; disp = d;
    in_valid = 1'b1;
    sb.push_back(model(m, b, x, s, d, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: compare each valid result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10", "valid without request", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_offset == e.off, e.tag, "offset", out_offset, e.off);
        check(out_mem == e.mem, e.tag, "mem flag", {31'd0, out_mem}, {31'd0, e.mem});
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0020;
    regs[2] = 32'h1234_5678; regs[3] = 32'h0000_0003;
    regs[4] = 32'hFFFF_FFF0; regs[5] = 32'h8000_0000;
    regs[6] = 32'h0000_0100; regs[7] = 32'hDEAD_BEEF;
    mode = 4'd7; disp = 32'h5555_5555; base_sel = 3'd7;
    repeat (3) @(negedge clk);
    // R11: outputs idle during reset
    check(!out_valid && out_offset == 0 && !out_mem, "R11", "during reset",
          out_offset, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && out_offset == 0 && !out_mem, "R11", "after reset",
          {31'd0, out_valid}, 32'd0);

    issue(4'd2, 3'd7, 3'd2, 2'd3, 32'h0003_FA00, "R1");
    issue(4'd3, 3'd2, 3'd7, 2'd1, 32'h0BAD_0BAD, "R2");
    issue(4'd4, 3'd6, 3'd0, 2'd0, 32'h1234_5680, "R3");   // -128, junk upper bits
    issue(4'd4, 3'd6, 3'd0, 2'd0, 32'hFFFF_FF7F, "R3");   // +127, junk upper bits
    issue(4'd5, 3'd0, 3'd1, 2'd2, 32'h0001_0000, "R4");
    for (int s = 0; s < 4; s++)
      issue(4'd7, 3'd0, 3'd3, 2'(s), 32'h0000_0040, "R5");
    issue(4'd6, 3'd6, 3'd1, 2'd2, 32'h0000_00F0, "R5");   // d8 = -16
    issue(4'd4, 3'd4, 3'd0, 2'd0, 32'h0000_0020, "R9");   // wraps to 0x10
    issue(4'd7, 3'd5, 3'd5, 2'd1, 32'h0000_0004, "R9");   // 0x80000000*3 wraps
    for (int k = 0; k < 8; k++)
      issue(4'd3, 3'(k), 3'd0, 2'd0, 32'd0, "R6");
    for (int k = 0; k < 8; k++)
      issue(4'd6, 3'd0, 3'(k), 2'd0, 32'd0, "R6");
    issue(4'd0, 3'd7, 3'd7, 2'd3, 32'hFFFF_FFFF, "R7");
    issue(4'd1, 3'd2, 3'd5, 2'd1, 32'h0000_1234, "R7");
    issue(4'd8, 3'd7, 3'd7, 2'd3, 32'hFFFF_FFFF, "R8");
    issue(4'd15, 3'd2, 3'd4, 2'd2, 32'h0000_0777, "R8");
    issue(4'd5, 3'd7, 3'd0, 2'd0, 32'h0000_0001, "R10");
    idle(1);
    // idle with new inputs: outputs must hold the last loaded result
    mode = 4'd2; disp = 32'hCAFE_0000;
    repeat (2) @(negedge clk);
    check(out_offset == 32'hDEAD_BEF0, "R10", "hold offset", out_offset, 32'hDEAD_BEF0);
    check(out_mem == 1'b1, "R10", "hold mem", {31'd0, out_mem}, 32'd1);
    check(!out_valid, "R10", "valid low while idle", {31'd0, out_valid}, 32'd0);
    check(sb.size() == 0, "R10", "every request answered", sb.size(), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule